// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the internal word address for a four-beat burst access to a synchronous memory array. A starting address is captured when an address strobe is asserted and the enable conditions hold. Each later advance request then steps to the next beat. Only the two lowest address bits move; the upper bits stay frozen until the next capture.

Two strobes can start a burst, and each is qualified differently. The controller strobe needs the complete chip select: the active-low enable, the active-high select and the active-low select. The processor strobe needs only the active-low enable, so the two auxiliary selects do not affect it. A static order input chooses the beat pattern. When it is low, the low bits count upward and wrap within the aligned group of four. When it is high, the low bits are the captured low bits XORed with the beat number.

The output address comes straight from registers. A capture or advance on one rising edge appears on `addr_out` right after that edge. The asynchronous reset is synchronised inside the block, so its release takes effect two clock edges after `rst_n` rises.

Top module: `bseq_burst_addr`

## Requirements
- R1: After reset, `addr_out` is all zeros.
- R2: On a rising edge with `strb_ctl_n`=0, `ce_n`=0, `cs_hi`=1 and `cs_lo_n`=0, the block captures the address, and `addr_out` equals `addr_in` after that edge.
- R3: On a rising edge with `strb_cpu_n`=0 and `ce_n`=0, the block captures the address whatever the values of `cs_hi` and `cs_lo_n`. While `ce_n`=1, `strb_cpu_n` has no effect on `addr_out`.
- R4: `strb_ctl_n`=0 causes no capture if any one of the three select terms is inactive (`ce_n`=1, `cs_hi`=0 or `cs_lo_n`=1). In that case `addr_out` does not change.
- R5: With no capture and `adv_n`=0, the beat number (0..3) increases by one modulo 4 on the edge. Bits `addr_out[AW-1:2]` keep their captured value.
- R6: With no capture and `adv_n`=1, `addr_out` holds its value.
- R7: With `order_il`=0, `addr_out[1:0]` equals (captured low bits + beat) modulo 4.
- R8: With `order_il`=1, `addr_out[1:0]` equals captured low bits XOR beat.
- R9: A capture has priority over an advance in the same cycle. It resets the beat to 0, so the first beat shows the captured address unchanged.
- R10: Advancing past the fourth beat wraps back to beat 0 and keeps cycling. The address never leaves the aligned group of four words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_in | input | AW | Starting address presented with a strobe |
| strb_ctl_n | input | 1 | Controller address strobe, active low, needs full chip select |
| strb_cpu_n | input | 1 | Processor address strobe, active low, gated by `ce_n` only |
| ce_n | input | 1 | Chip enable, active low |
| cs_hi | input | 1 | Chip select, active high |
| cs_lo_n | input | 1 | Chip select, active low |
| adv_n | input | 1 | Beat advance request, active low |
| order_il | input | 1 | Beat order: 0 linear, 1 interleaved; static |
| addr_out | output | AW | Internal word address for the current beat |

## Verification
The checks assume that `order_il` stays constant while the block is out of reset. One assertion watches this assumption directly. The bench changes the order input only while `rst_n` is low. It starts strobes and advances only after the two-edge reset synchroniser has released, so no capture is lost to the internal reset. All other inputs change on the falling clock edge, well away from the edge that registers them.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  localparam int unsigned BEAT_W = 2;
  localparam int unsigned BEATS  = 1 << BEAT_W;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;

  typedef logic [BEAT_W-1:0] beat_t;
endpackage

// File: rtl/bseq_rst_sync.sv
module bseq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/bseq_load_qual.sv
module bseq_load_qual (
  input  logic ce_n,
  input  logic cs_hi,
  input  logic cs_lo_n,
  input  logic strb_ctl_n,
  input  logic strb_cpu_n,
  output logic load
);
  logic full_sel;
  logic ctl_take;
  logic cpu_take;

  always_comb begin
    full_sel = !ce_n && cs_hi && !cs_lo_n;
    ctl_take = !strb_ctl_n && full_sel;
    cpu_take = !strb_cpu_n && !ce_n;
    load     = ctl_take || cpu_take;
  end
endmodule

// File: rtl/bseq_base_reg.sv
module bseq_base_reg #(
  parameter int unsigned AW = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] base
);
  logic [AW-1:0] base_q;
  logic [AW-1:0] base_d;

  always_comb begin
    base_d = base_q;
    if (load) base_d = addr_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= '0;
    else        base_q <= base_d;
  end

  assign base = base_q;

  // R9
  base_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> base == $past(addr_in));
  // R6
  base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(base));
endmodule

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr
  import bseq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  logic  adv_n,
  output beat_t beat
);
  beat_t beat_q;
  beat_t beat_d;
  logic  step_en;

  always_comb begin
    step_en = !load && !adv_n;
    beat_d  = beat_q;
    if (load)         beat_d = '0;
    else if (step_en) beat_d = beat_q + beat_t'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) beat_q <= '0;
    else        beat_q <= beat_d;
  end

  assign beat = beat_q;

  // R9
  beat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> beat == '0);
  // R5
  beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv_n) |=> beat == beat_t'($past(beat) + beat_t'(1)));
  // R6
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && adv_n) |=> $stable(beat));
endmodule

// File: rtl/bseq_order_map.sv
module bseq_order_map
  import bseq_pkg::*;
(
  input  beat_t  base_lo,
  input  beat_t  beat,
  input  order_e order,
  output beat_t  low_out
);
  beat_t lin_lo;
  beat_t ilv_lo;

  genvar gi;
  generate
    for (gi = 0; gi < BEAT_W; gi++) begin : g_ilv
      assign ilv_lo[gi] = base_lo[gi] ^ beat[gi];
    end
  endgenerate

  always_comb begin
    lin_lo  = base_lo + beat;
    low_out = (order == ORD_INTERLEAVE) ? ilv_lo : lin_lo;
  end
endmodule

// File: rtl/bseq_burst_addr.sv
module bseq_burst_addr
  import bseq_pkg::*;
#(
  parameter int unsigned AW         = 19,
  parameter int unsigned SYNC_STAGE = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_in,
  input  logic          strb_ctl_n,
  input  logic          strb_cpu_n,
  input  logic          ce_n,
  input  logic          cs_hi,
  input  logic          cs_lo_n,
  input  logic          adv_n,
  input  logic          order_il,
  output logic [AW-1:0] addr_out
);
  localparam int unsigned HI_W = AW - BEAT_W;

  logic          srst_n;
  logic          load;
  logic [AW-1:0] base;
  beat_t         beat;
  beat_t         low;
  order_e        order;

  assign order = order_e'(order_il);

  bseq_rst_sync #(.STAGES(SYNC_STAGE)) u_sync (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  bseq_load_qual u_qual (
    .ce_n(ce_n), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n),
    .strb_ctl_n(strb_ctl_n), .strb_cpu_n(strb_cpu_n), .load(load)
  );

  bseq_base_reg #(.AW(AW)) u_base (
    .clk(clk), .rst_n(srst_n), .load(load), .addr_in(addr_in), .base(base)
  );

  bseq_beat_ctr u_ctr (
    .clk(clk), .rst_n(srst_n), .load(load), .adv_n(adv_n), .beat(beat)
  );

  bseq_order_map u_map (
    .base_lo(base[BEAT_W-1:0]), .beat(beat), .order(order), .low_out(low)
  );

  assign addr_out = {base[AW-1:BEAT_W], low};

  // R8 (static order input assumed while running)
  order_static_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $stable(order_il));
  // R9
  first_beat_chk: assert property (@(posedge clk) disable iff (!srst_n)
    load |=> addr_out == $past(addr_in));
  // R5
  upper_fixed_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !load |=> addr_out[AW-1:BEAT_W] == $past(addr_out[AW-1:BEAT_W]));
  // R3
  cpu_gated_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (ce_n && adv_n) |=> $stable(addr_out));
  // R4
  ctl_desel_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (strb_cpu_n && adv_n && (!cs_hi || cs_lo_n)) |=> $stable(addr_out));

  initial begin
    hi_width_chk: assert (HI_W >= 1);
  end
endmodule

// File: tb/tb_bseq_burst_addr.sv
module tb_bseq_burst_addr;
  localparam int AW     = 6;
  localparam int CLK_PD = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr_in;
  logic          strb_ctl_n, strb_cpu_n, ce_n, cs_hi, cs_lo_n, adv_n, order_il;
  logic [AW-1:0] addr_out;

  int vecs = 0;
  int bad  = 0;
  bit done = 1'b0;

  always #(CLK_PD/2) clk = ~clk;

  bseq_burst_addr #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
    .strb_ctl_n(strb_ctl_n), .strb_cpu_n(strb_cpu_n),
    .ce_n(ce_n), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n),
    .adv_n(adv_n), .order_il(order_il), .addr_out(addr_out)
  );

  function automatic logic [AW-1:0] exp_addr(input int up, input int lo,
                                             input int b, input bit il);
    int low;
    low = il ? (lo ^ (b % 4)) : ((lo + b) % 4);
    return AW'(up * 4 + low);
  endfunction

  task automatic check(input string req, input logic [AW-1:0] exp);
    vecs++;
    if (addr_out !== exp) begin
      bad++;
      $display("FAIL %s: addr_out=%0h expected=%0h", req, addr_out, exp);
    end
  endtask

  task automatic idle();
    strb_ctl_n = 1'b1; strb_cpu_n = 1'b1;
    ce_n = 1'b0; cs_hi = 1'b1; cs_lo_n = 1'b0; adv_n = 1'b1;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input bit il);
    @(negedge clk);
    rst_n = 1'b0; idle(); addr_in = '0; order_il = il;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
  endtask

  initial begin
    #(CLK_PD * 150000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; idle(); addr_in = '0; order_il = 1'b0;
    for (int m = 0; m < 2; m++) begin
      do_reset(bit'(m));
      check("R1 reset value", '0);
      for (int up = 0; up < 16; up++) begin
        for (int lo = 0; lo < 4; lo++) begin
          addr_in = AW'(up * 4 + lo);
          if (lo[0]) begin
            strb_cpu_n = 1'b0; cs_hi = 1'b0; cs_lo_n = 1'b1;
          end else begin
            strb_ctl_n = 1'b0;
          end
          tick();
          idle();
          check(lo[0] ? "R3 cpu strobe capture" : "R2 ctl strobe capture",
                exp_addr(up, lo, 0, bit'(m)));
          for (int b = 1; b <= 6; b++) begin
            adv_n = 1'b0;
            tick();
            adv_n = 1'b1;
            check(m ? "R8 interleaved beat (R10 wrap)" : "R7 linear beat (R10 wrap)",
                  exp_addr(up, lo, b, bit'(m)));
            if (b == 2) begin
              tick();
              check("R6 hold without advance", exp_addr(up, lo, b, bit'(m)));
            end
          end
        end
      end
    end

    do_reset(1'b0);
    addr_in = AW'(6'h25); strb_ctl_n = 1'b0; tick(); idle();
    check("R2 setup", AW'(6'h25));
    adv_n = 1'b0; tick(); idle();
    check("R5 advance", AW'(6'h26));

    addr_in = AW'(6'h3A); strb_cpu_n = 1'b0; ce_n = 1'b1; tick(); idle();
    check("R3 cpu strobe ignored with ce_n high", AW'(6'h26));

    addr_in = AW'(6'h11); strb_ctl_n = 1'b0; ce_n = 1'b1; tick(); idle();
    check("R4 ctl strobe ignored with ce_n high", AW'(6'h26));
    strb_ctl_n = 1'b0; cs_hi = 1'b0; tick(); idle();
    check("R4 ctl strobe ignored with cs_hi low", AW'(6'h26));
    strb_ctl_n = 1'b0; cs_lo_n = 1'b1; tick(); idle();
    check("R4 ctl strobe ignored with cs_lo_n high", AW'(6'h26));

    addr_in = AW'(6'h1E); strb_ctl_n = 1'b0; adv_n = 1'b0; tick(); idle();
    check("R9 capture wins over advance", AW'(6'h1E));
    adv_n = 1'b0; tick(); idle();
    check("R10 linear wrap in group", AW'(6'h1F));
    adv_n = 1'b0; tick(); idle();
    check("R10 linear wrap in group", AW'(6'h1C));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule